// File: doc/BRIEF.md
# Pending Interrupt Priority Scanner

This block walks a pending bitmap of message-signalled interrupts and a matching configuration table. It picks the most urgent interrupt that is pending, enabled in its table entry and whose group is switched on. That interrupt is then weighed against a best candidate supplied from outside, which may come from another class of interrupt. The outcome is an updated best candidate and a flag that tells whether this class replaced it.

A scan starts on a one-cycle `start` pulse, and only if the master enable `lpi_en` is high. The scan reads one bitmap byte per cycle from a synchronous memory with one cycle of latency. Each byte covers eight IDs. In the same cycle it reads the eight matching configuration entries as one wide word. Every interrupt of this class belongs to the non-secure group 1, so the group reported for a winner is always that group's code. A restart pulse during a scan drops the scan in progress and begins again with freshly latched inputs.

Top module: `lpi_pend_scanner`

## Requirements
- R1: A `start` pulse with `lpi_en` low latches the incoming candidate onto the outputs, clears `new_win`, reads nothing and raises `done` in the cycle after the start edge; a pending, enabled interrupt then has no effect.
- R2: With default parameters (ID_BITS=13) the scanned IDs run from 8192 to 2^(ID_BITS+1)-1 = 16383, so `pend_addr` covers bytes 1024 to 2047 while `busy` is high and never goes below 1024.
- R3: The pending bit of ID n is bit n mod 8 of the bitmap byte at address n/8, with the read data returned one cycle after the address.
- R4: The configuration word read at `cfg_addr` = `pend_addr` - 1024 holds the entries for the eight IDs of that byte. Lane k sits in bits [9k+8:9k], with bit 9k+8 as the enable and bits [9k+7:9k] as the priority. The entry index of ID n is n - 8192.
- R5: While `grp_en` is low, no interrupt of this class qualifies and the latched candidate is kept.
- R6: An ID qualifies only when its pending bit, its entry enable and `grp_en` are all set.
- R7: A qualifying ID replaces the current best when its priority is numerically lower, or when the priorities are equal and its ID is lower. Otherwise the current best is kept.
- R8: On each replacement, `best_id`, `best_prio` and `best_grp` are updated, with `best_grp` = 2'b10 (non-secure group 1), and `new_win` goes high and stays high until the next `start`.
- R9: With `lpi_en` high, `done` goes high for one cycle at the 1025th clock edge after the edge that samples `start` (1024 bytes plus one cycle of read latency), and `busy` is high until then.
- R10: A `start` pulse during a scan abandons it, re-latches the incoming candidate and begins a full scan from the first byte.
- R11: After reset, `busy`, `done` and `new_win` are low, `best_prio` is 0xFF, `best_id` is all ones and `best_grp` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin (or restart) a scan; latches the incoming candidate |
| lpi_en | input | 1 | Master enable for this interrupt class, sampled at start |
| grp_en | input | 1 | Non-secure group 1 enable |
| in_id | input | ID_BITS+1 | Incoming best candidate ID |
| in_prio | input | 8 | Incoming best candidate priority |
| in_grp | input | 2 | Incoming best candidate group |
| pend_addr | output | ID_BITS-2 | Bitmap byte address |
| pend_data | input | 8 | Bitmap byte, one cycle after its address |
| cfg_addr | output | ID_BITS-2 | Configuration word address (eight entries) |
| cfg_data | input | 72 | Eight entries, each enable plus priority |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse at the end of a scan or skipped scan |
| best_id | output | ID_BITS+1 | Resulting best ID |
| best_prio | output | 8 | Resulting best priority |
| best_grp | output | 2 | Resulting best group |
| new_win | output | 1 | This class replaced the incoming candidate |

## Verification
Several stimulus patterns are used, and each one separates a different mistake:

- A single interrupt placed in the middle of a byte shows whether the bit and lane mapping is right. A mirrored lane order would report the wrong ID.
- Entries that are pending but disabled, enabled but not pending, or blocked because the group is off show whether all three qualification terms are ANDed together.
- Two entries with equal priority, plus a third with lower priority at a higher ID, separate comparison by priority from comparison by ID.
- Incoming candidates that tie on priority with a lower or a higher ID show the direction of the tie-break against the external winner.
- IDs placed at both ends of the range, the recorded span of addresses, a skipped scan and a restart in mid-scan show the boundaries of the range and the timing of `done`.

// File: rtl/lpi_pend_scanner.sv
module lpi_pend_scanner #(
  parameter int ID_BITS = 13,
  parameter int PRIO_W  = 8,
  parameter logic [1:0] LPI_GRP = 2'b10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 lpi_en,
  input  logic                 grp_en,
  input  logic [ID_BITS:0]     in_id,
  input  logic [PRIO_W-1:0]    in_prio,
  input  logic [1:0]           in_grp,
  output logic [ID_BITS-3:0]   pend_addr,
  input  logic [7:0]           pend_data,
  output logic [ID_BITS-3:0]   cfg_addr,
  input  logic [8*(PRIO_W+1)-1:0] cfg_data,
  output logic                 busy,
  output logic                 done,
  output logic [ID_BITS:0]     best_id,
  output logic [PRIO_W-1:0]    best_prio,
  output logic [1:0]           best_grp,
  output logic                 new_win
);
  localparam int IDW    = ID_BITS + 1;
  localparam int BAW    = IDW - 3;
  localparam int MIN_ID = 8192;
  localparam int EW     = PRIO_W + 1;
  localparam logic [BAW-1:0] FIRST = BAW'(MIN_ID / 8);
  localparam logic [BAW-1:0] LAST  = '1;

  if (ID_BITS < 13) begin : g_bad_width
    $error("ID_BITS must be at least 13");
  end

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_DRAIN} st_t;
  st_t st;

  logic [BAW-1:0]    a, ab;
  logic              vld;
  logic              hit;
  logic [IDW-1:0]    nid, kid;
  logic [PRIO_W-1:0] npr, kpr;
  logic              ok;

  assign pend_addr = a;
  assign cfg_addr  = a - FIRST;
  assign busy      = (st != S_IDLE);

  always_comb begin
    nid = best_id;
    npr = best_prio;
    hit = 1'b0;
    kid = '0;
    kpr = '0;
    ok  = 1'b0;
    for (int k = 0; k < 8; k++) begin
      kid = {ab, 3'(k)};
      kpr = cfg_data[k*EW +: PRIO_W];
      ok  = vld && grp_en && pend_data[k] && cfg_data[k*EW + PRIO_W];
      if (ok && ((kpr < npr) || (kpr == npr && kid < nid))) begin
        nid = kid;
        npr = kpr;
        hit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      a         <= '0;
      ab        <= '0;
      vld       <= 1'b0;
      done      <= 1'b0;
      best_id   <= '1;
      best_prio <= '1;
      best_grp  <= '0;
      new_win   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        best_id   <= in_id;
        best_prio <= in_prio;
        best_grp  <= in_grp;
        new_win   <= 1'b0;
        vld       <= 1'b0;
        if (lpi_en) begin
          st <= S_SCAN;
          a  <= FIRST;
        end else begin
          st   <= S_IDLE;
          done <= 1'b1;
        end
      end else begin
        if (hit) begin
          best_id   <= nid;
          best_prio <= npr;
          best_grp  <= LPI_GRP;
          new_win   <= 1'b1;
        end
        vld <= (st == S_SCAN);
        ab  <= a;
        case (st)
          S_SCAN: begin
            if (a == LAST) st <= S_DRAIN;
            else           a  <= a + 1'b1;
          end
          S_DRAIN: begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/lpi_pend_scanner_chk.sv
module lpi_pend_scanner_chk #(
  parameter int ID_BITS = 13,
  parameter int PRIO_W  = 8,
  parameter logic [1:0] LPI_GRP = 2'b10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               lpi_en,
  input logic               busy,
  input logic               done,
  input logic               new_win,
  input logic [PRIO_W-1:0]  best_prio,
  input logic [1:0]         best_grp,
  input logic [ID_BITS-3:0] pend_addr
);
  localparam logic [ID_BITS-3:0] FIRST = (ID_BITS-2)'(8192 / 8);

  a_r1_off_no_scan: assert property (@(posedge clk) disable iff (!rst_n)
    start && !lpi_en |=> done && !busy && !new_win);

  a_r2_addr_floor: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> pend_addr >= FIRST);

  a_r7_prio_never_worse: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !start |=> best_prio <= $past(best_prio));

  a_r8_grp_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    new_win |-> best_grp == LPI_GRP);

  a_r8_win_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    new_win && !start |=> new_win);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> !done);
endmodule

bind lpi_pend_scanner lpi_pend_scanner_chk #(
  .ID_BITS(ID_BITS), .PRIO_W(PRIO_W), .LPI_GRP(LPI_GRP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .lpi_en(lpi_en),
  .busy(busy), .done(done), .new_win(new_win), .best_prio(best_prio),
  .best_grp(best_grp), .pend_addr(pend_addr)
);

// File: tb/test_lpi_pend_scanner.sv
module test_lpi_pend_scanner;
  localparam int CLK_PERIOD = 10;
  localparam int ID_BITS = 13;
  localparam int IDW = ID_BITS + 1;
  localparam int BAW = IDW - 3;
  localparam int MIN_ID = 8192;
  localparam int ALL1 = (1 << IDW) - 1;
  localparam int SCAN_CYC = 1026;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, lpi_en = 1'b0, grp_en = 1'b1;
  logic [IDW-1:0] in_id = '0;
  logic [7:0] in_prio = '0;
  logic [1:0] in_grp = '0;
  logic [BAW-1:0] pend_addr, cfg_addr;
  logic [7:0] pend_data = '0;
  logic [71:0] cfg_data = '0;
  logic busy, done, new_win;
  logic [IDW-1:0] best_id;
  logic [7:0] best_prio;
  logic [1:0] best_grp;

  int total = 0, bad = 0;
  int amin, amax;
  logic [7:0] pmem [int];
  logic [8:0] cmem [int];

  always #(CLK_PERIOD/2) clk = ~clk;

  lpi_pend_scanner i_lpi_pend_scanner (
    .clk(clk), .rst_n(rst_n), .start(start), .lpi_en(lpi_en), .grp_en(grp_en),
    .in_id(in_id), .in_prio(in_prio), .in_grp(in_grp),
    .pend_addr(pend_addr), .pend_data(pend_data),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .busy(busy), .done(done), .best_id(best_id), .best_prio(best_prio),
    .best_grp(best_grp), .new_win(new_win));

  always @(posedge clk) begin
    pend_data <= pmem.exists(int'(pend_addr)) ? pmem[int'(pend_addr)] : 8'h00;
    for (int k = 0; k < 8; k++)
      cfg_data[k*9 +: 9] <= cmem.exists(int'(cfg_addr)*8 + k) ? cmem[int'(cfg_addr)*8 + k] : 9'h0;
    if (busy) begin
      if (int'(pend_addr) < amin) amin = int'(pend_addr);
      if (int'(pend_addr) > amax) amax = int'(pend_addr);
    end
  end

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    pmem.delete();
    cmem.delete();
    amin = 1 << 30;
    amax = -1;
  endtask

  task automatic set_lpi(int id, bit pend, bit en, int prio);
    if (pend) pmem[id/8] = (pmem.exists(id/8) ? pmem[id/8] : 8'h00) | 8'(1 << (id % 8));
    cmem[id - MIN_ID] = {en, 8'(prio)};
  endtask

  task automatic run(bit en, int id, int prio, int grp, output int cyc);
    @(negedge clk);
    start = 1'b1; lpi_en = en; in_id = IDW'(id); in_prio = 8'(prio); in_grp = 2'(grp);
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic t_reset();
    check("R11 busy", busy, 0);
    check("R11 done", done, 0);
    check("R11 new_win", new_win, 0);
    check("R11 best_prio", best_prio, 255);
    check("R11 best_id", best_id, ALL1);
    check("R11 best_grp", best_grp, 0);
  endtask

  task automatic t_off();
    int c;
    clear_mem();
    set_lpi(9000, 1, 1, 8'h10);
    run(0, 30, 8'h80, 1, c);
    check("R1 done cycle", c, 1);
    check("R1 id kept", best_id, 30);
    check("R1 prio kept", best_prio, 8'h80);
    check("R1 grp kept", best_grp, 1);
    check("R1 new_win", new_win, 0);
    check("R1 no reads", amax, -1);
  endtask

  task automatic t_timing();
    int c;
    clear_mem();
    run(1, 40, 8'h90, 0, c);
    check("R9 done cycle", c, SCAN_CYC);
    @(negedge clk);
    check("R9 done one cycle", done, 0);
    check("R9 idle after", busy, 0);
    check("R9 unchanged id", best_id, 40);
    check("R9 new_win", new_win, 0);
  endtask

  task automatic t_map();
    int c;
    clear_mem();
    set_lpi(8211, 1, 1, 8'h40);
    run(1, ALL1, 8'hFF, 0, c);
    check("R3 bit mapping id", best_id, 8211);
    check("R4 lane prio", best_prio, 8'h40);
    check("R8 grp", best_grp, 2);
    check("R8 new_win", new_win, 1);
  endtask

  task automatic t_qual();
    int c;
    clear_mem();
    set_lpi(8300, 1, 0, 8'h01);
    set_lpi(8400, 0, 1, 8'h02);
    set_lpi(9000, 1, 1, 8'h50);
    run(1, ALL1, 8'hFF, 0, c);
    check("R6 qualified id", best_id, 9000);
    check("R4 disabled entry skipped", best_prio, 8'h50);
  endtask

  task automatic t_grp();
    int c;
    clear_mem();
    set_lpi(9000, 1, 1, 8'h05);
    grp_en = 1'b0;
    run(1, 77, 8'hC0, 1, c);
    grp_en = 1'b1;
    check("R5 id kept", best_id, 77);
    check("R5 prio kept", best_prio, 8'hC0);
    check("R5 new_win", new_win, 0);
  endtask

  task automatic t_prio();
    int c;
    clear_mem();
    set_lpi(8200, 1, 1, 8'h30);
    set_lpi(8195, 1, 1, 8'h30);
    set_lpi(12000, 1, 1, 8'h20);
    run(1, ALL1, 8'hFF, 0, c);
    check("R7 lower prio wins id", best_id, 12000);
    check("R7 lower prio wins prio", best_prio, 8'h20);
    run(1, 100, 8'h20, 1, c);
    check("R7 tie keeps lower incoming id", best_id, 100);
    check("R7 tie new_win", new_win, 0);
    run(1, 13000, 8'h20, 1, c);
    check("R7 tie replaces higher incoming id", best_id, 12000);
    check("R8 grp on replace", best_grp, 2);
    clear_mem();
    set_lpi(8200, 1, 1, 8'h30);
    set_lpi(8195, 1, 1, 8'h30);
    run(1, ALL1, 8'hFF, 0, c);
    check("R7 equal prio lower id", best_id, 8195);
  endtask

  task automatic t_range();
    int c;
    clear_mem();
    set_lpi(16383, 1, 1, 8'h60);
    run(1, ALL1, 8'hFF, 0, c);
    check("R2 top id reached", best_id, 16383);
    check("R2 top id new_win", new_win, 1);
    check("R2 min addr", amin, 1024);
    check("R2 max addr", amax, 2047);
    set_lpi(8192, 1, 1, 8'h60);
    run(1, ALL1, 8'hFF, 0, c);
    check("R2 bottom id", best_id, 8192);
  endtask

  task automatic t_restart();
    int c;
    int seen;
    clear_mem();
    set_lpi(10000, 1, 1, 8'h30);
    @(negedge clk);
    start = 1'b1; lpi_en = 1'b1; in_id = IDW'(5); in_prio = 8'h00; in_grp = 2'd0;
    @(negedge clk);
    start = 1'b0;
    seen = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    check("R10 busy mid scan", busy, 1);
    run(1, ALL1, 8'hFF, 0, c);
    check("R10 no early done", seen, 0);
    check("R10 full rescan length", c, SCAN_CYC);
    check("R10 relatched result", best_id, 10000);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog R9 act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_off();
    t_timing();
    t_map();
    t_qual();
    t_grp();
    t_prio();
    t_range();
    t_restart();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule